// File: doc/BRIEF.md
# Prioritised Interrupt Router Core

This block collects level-sensitive interrupt requests from up to 31 peripheral sources and delivers them to two processor contexts. Each source has a small programmable priority. Each context has its own enable mask, a priority threshold, and a claim/complete register. Source numbers run from 1 upward. Number 0 is kept to mean "nothing to service".

A context handles an interrupt in two steps. It reads its claim register, which hands over the best eligible source and takes that source out of arbitration. When the handler is done, it writes the same number back to the claim register to complete the interrupt. A request line that is still high after completion raises a fresh pending request.

All programming uses one plain register bus that serves one access per cycle: an address, a read strobe, a write strobe, write data, and registered read data. Read data appears the cycle after the read strobe. The bus never stalls, so there is no back-pressure and no ready signal. Every access completes in the cycle it is presented.

Top module: `plic_core`

## Requirements
- R1: After reset all priorities, enables and thresholds are 0, every pending and claimed state is clear, both `irq_o` bits are 0, and a claim read returns 0.
- R2: Source k's priority sits at byte address 4·k and holds 3 bits; bits above bit 2 read as 0. Address 0 (no source) reads 0 and ignores writes.
- R3: Context c's enable word sits at 0x2000 + 0x80·c; bit k enables source k. Bit 0 reads as 0.
- R4: Context c's threshold sits at 0x200000 + 0x1000·c and holds 3 bits. Its claim/complete register is at that address + 4.
- R5: A source is eligible for a context only when it is pending, enabled there, and its priority is strictly above that context's threshold. Priority 0 is never eligible, and threshold 7 blocks everything.
- R6: `irq_o[c]` is the OR of context c's eligible sources. It changes one cycle after the state change that causes it.
- R7: A claim returns the eligible source with the highest priority. Among equal priorities, the smallest source number wins.
- R8: A claim read returns the winner in the next cycle, or 0 if nothing is eligible. It also clears that source's pending state, and the source raises no new request until it is completed.
- R9: Writing a claimed source number to the claim register of a context that has that source enabled completes it. A request line that is still high then becomes pending again.
- R10: A completion write is ignored when the number is not currently claimed, or when the source is not enabled for the writing context.
- R11: A source is never handed to two contexts. After one context claims it, the other context's claim returns the next-best source or 0.
- R12: A pending request is latched: it stays pending after the request line drops, until it is claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_irq_i | input | NUM_SRC | Level requests; bit k is source k (indices NUM_SRC..1) |
| bus_addr_i | input | 22 | Byte address |
| bus_re_i | input | 1 | Read strobe; a claim read has side effects |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| irq_o | output | NUM_CTX | Interrupt line per context |

## Verification
Arbitration is exercised with a table of request masks, enable masks and thresholds. One entry isolates strict priority order. Others separate ties at the top priority, where the lowest number wins. Further entries show an enable mask removing the natural winner, the strict compare at the threshold, and a zero-priority source. Directed patterns then cover what the table cannot. One is a source still held high after completion, which must re-arm. Another is a one-cycle pulse, which must stay latched. Bogus completions must leave a claim in place, and two contexts competing for overlapping sources must never receive the same number.

// File: rtl/plic_core_pkg.sv
package plic_core_pkg;
  localparam int ADDR_W = 22;
  localparam int DATA_W = 32;

  localparam int PRIO_STRIDE = 4;
  localparam int EN_BASE     = 32'h0000_2000;
  localparam int EN_STRIDE   = 32'h80;
  localparam int CTX_BASE    = 32'h0020_0000;
  localparam int CTX_STRIDE  = 32'h1000;
  localparam int THR_OFS     = 0;
  localparam int CLM_OFS     = 4;

  function automatic logic [ADDR_W-1:0] prio_addr(input int id);
    return ADDR_W'(id * PRIO_STRIDE);
  endfunction

  function automatic logic [ADDR_W-1:0] en_addr(input int ctx);
    return ADDR_W'(EN_BASE + ctx * EN_STRIDE);
  endfunction

  function automatic logic [ADDR_W-1:0] thr_addr(input int ctx);
    return ADDR_W'(CTX_BASE + ctx * CTX_STRIDE + THR_OFS);
  endfunction

  function automatic logic [ADDR_W-1:0] clm_addr(input int ctx);
    return ADDR_W'(CTX_BASE + ctx * CTX_STRIDE + CLM_OFS);
  endfunction
endpackage

// File: rtl/plic_gateway.sv
// Per-source request latch: pending until claimed, then held off until completed.
module plic_gateway #(
  parameter int NUM_SRC = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_SRC:1] level_i,
  input  logic [NUM_SRC:1] claim_i,
  input  logic [NUM_SRC:1] complete_i,
  output logic [NUM_SRC:1] pending_o,
  output logic [NUM_SRC:1] claimed_o
);
  for (genvar i = 1; i <= NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pending_o[i] <= 1'b0;
        claimed_o[i] <= 1'b0;
      end else if (claim_i[i]) begin
        pending_o[i] <= 1'b0;
        claimed_o[i] <= 1'b1;
      end else begin
        if (complete_i[i])
          claimed_o[i] <= 1'b0;
        if (level_i[i] && !claimed_o[i])
          pending_o[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/plic_target.sv
// Per-context eligibility, best-source selection and registered interrupt line.
module plic_target #(
  parameter int NUM_SRC = 31,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC:1]          pending_i,
  input  logic [NUM_SRC:1]          enable_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]         thr_i,
  output logic [ID_W-1:0]           win_id_o,
  output logic                      irq_o
);
  logic [NUM_SRC:1]  elig;
  logic [PRIO_W-1:0] best_p;

  always_comb begin
    for (int i = 1; i <= NUM_SRC; i++)
      elig[i] = pending_i[i] && enable_i[i] &&
                (prio_i[(i-1)*PRIO_W +: PRIO_W] > thr_i);
  end

  // Ascending scan with a strict compare keeps the lowest number on ties.
  always_comb begin
    best_p   = '0;
    win_id_o = '0;
    for (int i = 1; i <= NUM_SRC; i++) begin
      if (elig[i] && (prio_i[(i-1)*PRIO_W +: PRIO_W] > best_p)) begin
        best_p   = prio_i[(i-1)*PRIO_W +: PRIO_W];
        win_id_o = ID_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |elig;
  end
endmodule

// File: rtl/plic_core.sv
module plic_core
  import plic_core_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC:1]   src_irq_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic               bus_re_i,
  input  logic               bus_we_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic [NUM_CTX-1:0] irq_o
);
  localparam int ID_W = $clog2(NUM_SRC + 1);

  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic [NUM_SRC:1]          en_q [NUM_CTX];
  logic [PRIO_W-1:0]         thr_q [NUM_CTX];
  logic [ID_W-1:0]           win_id [NUM_CTX];
  logic [NUM_SRC:1]          pending, claimed;
  logic [NUM_SRC:1]          claim_vec, cmpl_vec;
  logic [NUM_CTX-1:0]        claim_stb;
  logic [DATA_W-1:0]         rd_val;

  // Priority registers
  for (genvar i = 1; i <= NUM_SRC; i++) begin : g_prio
    always_ff @(posedge clk) begin
      if (!rst_n)
        prio_flat[(i-1)*PRIO_W +: PRIO_W] <= '0;
      else if (bus_we_i && bus_addr_i == prio_addr(i))
        prio_flat[(i-1)*PRIO_W +: PRIO_W] <= bus_wdata_i[PRIO_W-1:0];
    end
  end

  // Per-context enable and threshold, plus the target logic
  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q[c]  <= '0;
        thr_q[c] <= '0;
      end else if (bus_we_i) begin
        if (bus_addr_i == en_addr(c))  en_q[c]  <= bus_wdata_i[NUM_SRC:1];
        if (bus_addr_i == thr_addr(c)) thr_q[c] <= bus_wdata_i[PRIO_W-1:0];
      end
    end

    plic_target #(
      .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)
    ) u_target (
      .clk      (clk),
      .rst_n    (rst_n),
      .pending_i(pending),
      .enable_i (en_q[c]),
      .prio_i   (prio_flat),
      .thr_i    (thr_q[c]),
      .win_id_o (win_id[c]),
      .irq_o    (irq_o[c])
    );
  end

  // Claim and completion decode; lower context index takes a source first.
  always_comb begin
    claim_vec = '0;
    cmpl_vec  = '0;
    claim_stb = '0;
    for (int c = 0; c < NUM_CTX; c++) begin
      if (bus_re_i && bus_addr_i == clm_addr(c)) begin
        claim_stb[c] = 1'b1;
        for (int i = 1; i <= NUM_SRC; i++)
          if (win_id[c] == ID_W'(i) && !claim_vec[i]) claim_vec[i] = 1'b1;
      end
      if (bus_we_i && bus_addr_i == clm_addr(c)) begin
        for (int i = 1; i <= NUM_SRC; i++)
          if (bus_wdata_i == DATA_W'(i) && claimed[i] && en_q[c][i])
            cmpl_vec[i] = 1'b1;
      end
    end
  end

  plic_gateway #(.NUM_SRC(NUM_SRC)) u_gateway (
    .clk       (clk),
    .rst_n     (rst_n),
    .level_i   (src_irq_i),
    .claim_i   (claim_vec),
    .complete_i(cmpl_vec),
    .pending_o (pending),
    .claimed_o (claimed)
  );

  // Read mux, registered on the read strobe
  always_comb begin
    rd_val = '0;
    for (int i = 1; i <= NUM_SRC; i++)
      if (bus_addr_i == prio_addr(i))
        rd_val[PRIO_W-1:0] = prio_flat[(i-1)*PRIO_W +: PRIO_W];
    for (int c = 0; c < NUM_CTX; c++) begin
      if (bus_addr_i == en_addr(c))  rd_val[NUM_SRC:1]  = en_q[c];
      if (bus_addr_i == thr_addr(c)) rd_val[PRIO_W-1:0] = thr_q[c];
      if (claim_stb[c])              rd_val[ID_W-1:0]   = win_id[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        bus_rdata_o <= '0;
    else if (bus_re_i) bus_rdata_o <= rd_val;
  end
endmodule

// File: rtl/plic_core_chk.sv
module plic_core_chk
  import plic_core_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [ADDR_W-1:0]         bus_addr_i,
  input logic                      bus_re_i,
  input logic                      bus_we_i,
  input logic [DATA_W-1:0]         bus_wdata_i,
  input logic [NUM_SRC:1]          pending,
  input logic [NUM_SRC:1]          claimed,
  input logic [NUM_SRC:1]          claim_vec,
  input logic [NUM_CTX-1:0]        irq_o,
  input logic [NUM_CTX*PRIO_W-1:0] thr_flat
);
  logic clm_rd, clm_wr, wr_hits_claimed;

  always_comb begin
    clm_rd = 1'b0;
    clm_wr = 1'b0;
    for (int c = 0; c < NUM_CTX; c++) begin
      if (bus_re_i && bus_addr_i == clm_addr(c)) clm_rd = 1'b1;
      if (bus_we_i && bus_addr_i == clm_addr(c)) clm_wr = 1'b1;
    end
    wr_hits_claimed = 1'b0;
    for (int i = 1; i <= NUM_SRC; i++)
      if (bus_wdata_i == DATA_W'(i) && claimed[i]) wr_hits_claimed = 1'b1;
  end

  // R8: a claimed source never carries a pending request
  assert_no_pend_when_claimed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pending & claimed) == '0);

  // R11: a claim hands out at most one source
  assert_single_handout_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim_vec));

  // R8: a successful claim adds exactly one claimed source
  assert_claim_marks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clm_rd && claim_vec != '0) |=> $countones(claimed) == $countones($past(claimed)) + 1);

  // R10: completing an unclaimed number leaves the claimed set alone
  assert_bogus_complete_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clm_wr && !wr_hits_claimed) |=> claimed == $past(claimed));

  // R5: the top threshold silences a context
  for (genvar c = 0; c < NUM_CTX; c++) begin : g_thr
    assert_thr_max_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_flat[c*PRIO_W +: PRIO_W] == {PRIO_W{1'b1}}) |=> !irq_o[c]);
  end
endmodule

bind plic_core plic_core_chk #(
  .NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr_i (bus_addr_i),
  .bus_re_i   (bus_re_i),
  .bus_we_i   (bus_we_i),
  .bus_wdata_i(bus_wdata_i),
  .pending    (pending),
  .claimed    (claimed),
  .claim_vec  (claim_vec),
  .irq_o      (irq_o),
  .thr_flat   ({thr_q[1], thr_q[0]})
);

// File: tb/plic_core_test.sv
`timescale 1ns/1ps
module plic_core_test;
  localparam logic [21:0] EN0  = 22'h2000,   EN1  = 22'h2080;
  localparam logic [21:0] THR0 = 22'h200000, CLM0 = 22'h200004;
  localparam logic [21:0] THR1 = 22'h201000, CLM1 = 22'h201004;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:1] src = '0;
  logic [21:0] addr = '0;
  logic        re = 1'b0, we = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic [1:0]  irq;
  int n_chk = 0, n_bad = 0;
  logic [31:0] d;

  plic_core uut (
    .clk(clk), .rst_n(rst_n), .src_irq_i(src), .bus_addr_i(addr),
    .bus_re_i(re), .bus_we_i(we), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  always #10 clk = ~clk;

  // mask[71:40] request bits by source number, en[39:8], thr[7:5], expected id[4:0]
  localparam int NV = 10;
  localparam logic [71:0] VEC [NV] = '{
    {32'h0000_0008, 32'hFFFF_FFFE, 3'd0, 5'd3},   // R7 single
    {32'h0000_0028, 32'hFFFF_FFFE, 3'd0, 5'd5},   // R7 priority order
    {32'h0000_8080, 32'hFFFF_FFFE, 3'd0, 5'd7},   // R7 tie low id
    {32'h0000_0060, 32'hFFFF_FFBE, 3'd0, 5'd5},   // R5 enable mask
    {32'h0000_0060, 32'hFFFF_FFFE, 3'd5, 5'd6},   // R5 above threshold
    {32'h0000_0020, 32'hFFFF_FFFE, 3'd5, 5'd0},   // R5 strict compare
    {32'h0000_0100, 32'hFFFF_FFFE, 3'd0, 5'd0},   // R5 priority zero
    {32'h0000_0604, 32'hFFFF_FFFE, 3'd0, 5'd2},   // R7 tie at prio 2
    {32'h8080_0000, 32'hFFFF_FFFE, 3'd0, 5'd23},  // R7 tie at top ids
    {32'h0000_0000, 32'hFFFF_FFFE, 3'd0, 5'd0}    // R8 nothing eligible
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [21:0] a, input logic [31:0] v);
    addr = a; wdata = v; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [21:0] a, output logic [31:0] v);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    v = rdata;
  endtask

  task automatic drain();
    logic [31:0] id;
    src = '0;
    wr(22'd32, 1); wr(22'd64, 1); wr(22'd96, 1);
    wr(EN0, 32'hFFFF_FFFE); wr(THR0, 0);
    for (int k = 0; k < 40; k++) begin
      rd(CLM0, id);
      if (id == 0) break;
      wr(CLM0, id);
    end
    wr(22'd32, 0); wr(22'd64, 0); wr(22'd96, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {30'd0, irq}, 0);
    rd(22'd20, d); chk("R1 prio5", d, 0);
    rd(EN0, d);    chk("R1 en0", d, 0);
    rd(THR0, d);   chk("R1 thr0", d, 0);
    rd(CLM0, d);   chk("R1 claim0", d, 0);

    // R2 priority width and id 0
    wr(22'd20, 32'hFFFF_FFFF); rd(22'd20, d); chk("R2 prio5 width", d, 7);
    wr(22'd0, 32'hFF);         rd(22'd0, d);  chk("R2 id0 reads 0", d, 0);
    // R3 enable word, bit 0
    wr(EN1, 32'hFFFF_FFFF); rd(EN1, d); chk("R3 en1", d, 32'hFFFF_FFFE);
    wr(EN1, 0);
    // R4 threshold width
    wr(THR1, 32'hFFFF_FFFF); rd(THR1, d); chk("R4 thr1", d, 7);
    wr(THR1, 0);

    for (int i = 1; i <= 31; i++) wr(22'(i * 4), i & 7);

    // R5 R6 R7 R8 table
    for (int v = 0; v < NV; v++) begin
      wr(EN0, VEC[v][39:8]);
      wr(THR0, 32'(VEC[v][7:5]));
      src = VEC[v][71:41];
      repeat (2) @(negedge clk);
      chk($sformatf("R6 irq vec%0d", v), 32'(irq[0]), 32'(VEC[v][4:0] != 0));
      rd(CLM0, d);
      chk($sformatf("R7 claim vec%0d", v), d, 32'(VEC[v][4:0]));
      if (d != 0) wr(CLM0, d);
      drain();
    end

    // R6 timing and R5 threshold 7
    wr(THR0, 7); src[5] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 thr7 quiet", 32'(irq[0]), 0);
    wr(THR0, 0);
    chk("R6 not yet", 32'(irq[0]), 0);
    @(negedge clk);
    chk("R6 one cycle later", 32'(irq[0]), 1);
    rd(CLM0, d); wr(CLM0, d); drain();

    // R8 hold-off
    src[4] = 1'b1;
    repeat (2) @(negedge clk);
    rd(CLM0, d); chk("R8 claim 4", d, 4);
    repeat (2) @(negedge clk);
    chk("R8 irq drops", 32'(irq[0]), 0);
    rd(CLM0, d); chk("R8 held off", d, 0);
    // R10 bogus completions
    wr(CLM0, 5); wr(CLM1, 4);
    repeat (2) @(negedge clk);
    chk("R10 irq stays low", 32'(irq[0]), 0);
    rd(CLM0, d); chk("R10 still claimed", d, 0);
    // R9 completion re-arms a held level
    wr(CLM0, 4);
    repeat (2) @(negedge clk);
    chk("R9 irq again", 32'(irq[0]), 1);
    rd(CLM0, d); chk("R9 claim again", d, 4);
    wr(CLM0, 4); drain();

    // R12 latched pulse
    src[3] = 1'b1; @(negedge clk); src[3] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 pulse latched", 32'(irq[0]), 1);
    rd(CLM0, d); chk("R12 claim 3", d, 3);
    wr(CLM0, d); drain();

    // R11 two contexts
    wr(EN1, 32'hFFFF_FFFE);
    src[4] = 1'b1; src[6] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 both irq", {30'd0, irq}, 3);
    rd(CLM0, d); chk("R11 ctx0 gets 6", d, 6);
    rd(CLM1, d); chk("R11 ctx1 gets 4", d, 4);
    rd(CLM1, d); chk("R11 ctx1 empty", d, 0);
    rd(CLM0, d); chk("R11 ctx0 empty", d, 0);
    src = '0;
    wr(CLM0, 6); wr(CLM1, 4);
    repeat (2) @(negedge clk);
    chk("R11 all quiet", {30'd0, irq}, 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule